// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits beside a code flash region and watches the 32-bit writes that target it. The flash controller accepts commands only as short chains of writes: an unlock pair, then a command write, and for some commands further unlock or payload writes. The decoder follows these chains, compares each write's command-address field (address bits [11:4]) and the low byte of its data against what the current step expects, and records the target address and, for programming, four data words. When a chain is complete it raises a single-cycle request carrying an operation code, the target address and the program words. The erase and program engines use that request.

A write that breaks the chain drops the decoder back to idle and issues nothing. While the array engine reports busy, writes are not seen at all. After an ID-read chain the decoder tells the read path that the next bus read must return the device identifier rather than array data.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, op_valid_o and id_sel_o are low, and the decoder is idle.
- R2: In idle, a write whose low data byte is 0xF0 produces a reset request (op code 0) whose address is that write's address. The upper 24 data bits are ignored.
- R3: A chain starts with low byte 0xAA with address field [11:4]=0x55, followed by 0x55 with field 0xAA. The command write goes to field 0x55. Only data bits [7:0] are compared.
- R4: An ID read is the command byte 0x90 followed by a write of 0x00. It gives op code 1 with that write's address. id_sel_o then stays high until a cycle with rd_valid_i high, and is low from the next cycle on.
- R5: Programming is the command byte 0xA0 followed by four writes to one address. It gives op code 2 with that address. Word k of the program data sits in op_data_o[32k+31:32k], k=0 being the first.
- R6: A program data write to an address different from the first data write's address aborts the chain without a request.
- R7: The erase group is 0x80, then 0xAA at field 0x55, then 0x55 at field 0xAA, then a selecting write. Page erase is 0x40 (op 3), block erase is 0x30 (op 4) and area erase is 0x20 (op 5). Each carries the selecting write's address.
- R8: Code-area erase (0x11, op 6) and chip erase (0x10, op 7) are valid only at field 0x55. At any other field the chain aborts.
- R9: Protect-bit programming is the command byte 0x9A followed by a write of 0x9A. It gives op code 8 with that second write's address.
- R10: A write that does not match the current step returns the decoder to idle with no request. A 0xF0 write in any step outside the program data phase issues a reset request and returns to idle. In the data phase, 0xF0 is ordinary data.
- R11: While busy_i is high, writes are ignored: they do not advance the chain, abort it, or produce a request.
- R12: op_valid_o is high for exactly the one cycle after the write that completes a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Bus write cycle to the flash region |
| wr_addr_i | input | 32 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_valid_i | input | 1 | Bus read cycle to the flash region |
| busy_i | input | 1 | Array engine busy; writes are ignored |
| op_valid_o | output | 1 | One-cycle operation request |
| op_code_o | output | 4 | Operation code |
| op_addr_o | output | 32 | Target address of the request |
| op_data_o | output | 128 | Captured program words |
| id_sel_o | output | 1 | Next read returns the ID value |

## Verification
The scoreboard drives every command with junk in the upper data bits. A decoder that compared the full word would then never issue a request. The bench breaks chains in three ways: a wrong address field on the second unlock, a moved program address, and chip erase aimed away from field 0x55. A decoder that failed to abort on any of these would produce a request the scoreboard does not expect. A 0xF0 program word must come out as data. A decoder that applied the reset rule inside the data phase would issue a spurious reset request and lose the program. A busy write placed between unlock steps must leave the chain intact. A decoder that sampled it would either abort or advance on it.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  localparam logic [7:0] C_RESET = 8'hF0;
  localparam logic [7:0] C_UL1   = 8'hAA;
  localparam logic [7:0] C_UL2   = 8'h55;
  localparam logic [7:0] C_ID    = 8'h90;
  localparam logic [7:0] C_ID2   = 8'h00;
  localparam logic [7:0] C_PROG  = 8'hA0;
  localparam logic [7:0] C_ERASE = 8'h80;
  localparam logic [7:0] C_PROT  = 8'h9A;
  localparam logic [7:0] C_PAGE  = 8'h40;
  localparam logic [7:0] C_BLOCK = 8'h30;
  localparam logic [7:0] C_AREA  = 8'h20;
  localparam logic [7:0] C_CODE  = 8'h11;
  localparam logic [7:0] C_CHIP  = 8'h10;

  typedef enum logic [3:0] {
    OP_RESET = 4'd0, OP_ID = 4'd1, OP_PROG = 4'd2, OP_PAGE = 4'd3, OP_BLOCK = 4'd4,
    OP_AREA = 4'd5, OP_CODE = 4'd6, OP_CHIP = 4'd7, OP_PROT = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UL2, ST_CMD, ST_IDA, ST_IDW, ST_PROT, ST_PROG, ST_ER4, ST_ER5, ST_ER6
  } st_e;
endpackage

// File: rtl/fcmd_field.sv
module fcmd_field #(
  parameter int CF_W = 8
) (
  input  logic [CF_W-1:0] field_i,
  output logic            f55_o,
  output logic            faa_o
);
  assign f55_o = (field_i == CF_W'(8'h55));
  assign faa_o = (field_i == CF_W'(8'hAA));
endmodule

// File: rtl/fcmd_pdata.sv
module fcmd_pdata #(
  parameter int DW     = 32,
  parameter int NWORDS = 4,
  localparam int IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [IDXW-1:0]      idx_i,
  input  logic [DW-1:0]        data_i,
  output logic [DW*NWORDS-1:0] words_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [DW-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                w_q <= '0;
      else if (we_i && idx_i == IDXW'(g))         w_q <= data_i;
    end
    assign words_o[g*DW +: DW] = w_q;
  end
endmodule

// File: rtl/fcmd_fsm.sv
module fcmd_fsm
  import fcmd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NWORDS = 4,
  localparam int IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            acc_i,
  input  logic            rd_valid_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      code_i,
  input  logic            f55_i,
  input  logic            faa_i,
  output logic            fire_o,
  output op_e             op_o,
  output logic            we_o,
  output logic [IDXW-1:0] idx_o,
  output logic            id_wait_o
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NWORDS - 1);

  st_e             st_q, st_d;
  logic [IDXW-1:0] cnt_q, cnt_d;
  logic [AW-1:0]   paddr_q, paddr_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; paddr_d = paddr_q;
    fire_o = 1'b0; op_o = OP_RESET; we_o = 1'b0;
    if (st_q == ST_IDW && rd_valid_i) st_d = ST_IDLE;
    if (acc_i) begin
      if (code_i == C_RESET && st_q != ST_PROG) begin
        fire_o = 1'b1; op_o = OP_RESET; st_d = ST_IDLE;
      end else begin
        st_d = ST_IDLE;  // any mismatch aborts
        case (st_q)
          ST_IDLE: if (code_i == C_UL1 && f55_i) st_d = ST_UL2;
          ST_UL2:  if (code_i == C_UL2 && faa_i) st_d = ST_CMD;
          ST_CMD: if (f55_i) begin
            case (code_i)
              C_ID:    st_d = ST_IDA;
              C_PROG:  begin st_d = ST_PROG; cnt_d = '0; end
              C_ERASE: st_d = ST_ER4;
              C_PROT:  st_d = ST_PROT;
              default: st_d = ST_IDLE;
            endcase
          end
          ST_IDA: if (code_i == C_ID2) begin
            fire_o = 1'b1; op_o = OP_ID; st_d = ST_IDW;
          end
          ST_PROT: if (code_i == C_PROT) begin
            fire_o = 1'b1; op_o = OP_PROT;
          end
          ST_PROG: if (cnt_q == '0 || addr_i == paddr_q) begin
            we_o = 1'b1;
            if (cnt_q == '0) paddr_d = addr_i;
            if (cnt_q == LAST) begin
              fire_o = 1'b1; op_o = OP_PROG;
            end else begin
              cnt_d = cnt_q + IDXW'(1); st_d = ST_PROG;
            end
          end
          ST_ER4: if (code_i == C_UL1 && f55_i) st_d = ST_ER5;
          ST_ER5: if (code_i == C_UL2 && faa_i) st_d = ST_ER6;
          ST_ER6: begin
            fire_o = 1'b1;
            if      (code_i == C_PAGE)          op_o = OP_PAGE;
            else if (code_i == C_BLOCK)         op_o = OP_BLOCK;
            else if (code_i == C_AREA)          op_o = OP_AREA;
            else if (code_i == C_CODE && f55_i) op_o = OP_CODE;
            else if (code_i == C_CHIP && f55_i) op_o = OP_CHIP;
            else                                fire_o = 1'b0;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; paddr_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; paddr_q <= paddr_d;
    end
  end

  assign idx_o     = cnt_q;
  assign id_wait_o = (st_q == ST_IDW);
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int CF_LSB = 4,
  parameter int CF_W   = 8,
  parameter int NWORDS = 4,
  localparam int IDXW  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_valid_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [DW-1:0]        wr_data_i,
  input  logic                 rd_valid_i,
  input  logic                 busy_i,
  output logic                 op_valid_o,
  output logic [3:0]           op_code_o,
  output logic [AW-1:0]        op_addr_o,
  output logic [DW*NWORDS-1:0] op_data_o,
  output logic                 id_sel_o
);
  logic            acc, f55, faa, fire, we;
  op_e             op;
  logic [IDXW-1:0] idx;

  assign acc = wr_valid_i && !busy_i;

  fcmd_field #(.CF_W(CF_W)) u_field (
    .field_i(wr_addr_i[CF_LSB +: CF_W]), .f55_o(f55), .faa_o(faa)
  );

  fcmd_fsm #(.AW(AW), .NWORDS(NWORDS)) u_fsm (
    .clk_i, .rst_ni, .acc_i(acc), .rd_valid_i, .addr_i(wr_addr_i),
    .code_i(wr_data_i[7:0]), .f55_i(f55), .faa_i(faa),
    .fire_o(fire), .op_o(op), .we_o(we), .idx_o(idx), .id_wait_o(id_sel_o)
  );

  fcmd_pdata #(.DW(DW), .NWORDS(NWORDS)) u_pdata (
    .clk_i, .rst_ni, .we_i(we), .idx_i(idx), .data_i(wr_data_i), .words_o(op_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_valid_o <= 1'b0; op_code_o <= 4'd0; op_addr_o <= '0;
    end else begin
      op_valid_o <= fire;
      if (fire) begin
        op_code_o <= op;
        op_addr_o <= wr_addr_i;
      end
    end
  end
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NWORDS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_valid_i,
  input logic [DW-1:0]        wr_data_i,
  input logic                 rd_valid_i,
  input logic                 busy_i,
  input logic                 op_valid_o,
  input logic [3:0]           op_code_o,
  input logic [DW*NWORDS-1:0] op_data_o,
  input logic                 id_sel_o
);
  // R12
  req_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> $past(wr_valid_i));
  // R11
  busy_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !op_valid_o);
  // R2
  reset_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_code_o == 4'd0) |-> $past(wr_data_i[7:0]) == 8'hF0);
  // R4
  id_sel_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_sel_o) |-> (op_valid_o && op_code_o == 4'd1));
  // R4
  id_sel_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_sel_o && rd_valid_i) |=> !id_sel_o);
  // R5
  prog_last_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_code_o == 4'd2) |-> $past(wr_data_i) == op_data_o[DW*NWORDS-1 -: DW]);
endmodule

bind fcmd_decoder fcmd_decoder_chk #(.AW(AW), .DW(DW), .NWORDS(NWORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
  .rd_valid_i(rd_valid_i), .busy_i(busy_i), .op_valid_o(op_valid_o),
  .op_code_o(op_code_o), .op_data_o(op_data_o), .id_sel_o(id_sel_o)
);

// File: tb/fcmd_decoder_tb_top.sv
module fcmd_decoder_tb_top;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         wr_valid = 1'b0, rd_valid = 1'b0, busy = 1'b0;
  logic [31:0]  wr_addr = '0, wr_data = '0;
  logic         op_valid, id_sel;
  logic [3:0]   op_code;
  logic [31:0]  op_addr;
  logic [127:0] op_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0]   code;
    logic [31:0]  addr;
    logic [127:0] data;
    bit           chk_data;
    string        req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz

  fcmd_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_valid_i(rd_valid), .busy_i(busy), .op_valid_o(op_valid),
    .op_code_o(op_code), .op_addr_o(op_addr), .op_data_o(op_data), .id_sel_o(id_sel)
  );

  function automatic logic [31:0] fa(logic [7:0] f);
    return 32'h0002_3000 | (32'(f) << 4) | 32'h8;
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expect_op(logic [3:0] c, logic [31:0] a, logic [127:0] d, bit cd, string r);
    exp_t e;
    e.code = c; e.addr = a; e.data = d; e.chk_data = cd; e.req = r;
    q.push_back(e);
  endtask

  task automatic unlock();
    wr(fa(8'h55), 32'h1234_56AA);
    wr(fa(8'hAA), 32'hCAFE_0055);
  endtask

  task automatic drained(string r);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, r, 128'(q.size()), 128'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R10 unexpected request", 128'(op_code), 128'hF);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(op_code == e.code, {e.req, " code"}, 128'(op_code), 128'(e.code));
        chk(op_addr == e.addr, {e.req, " addr"}, 128'(op_addr), 128'(e.addr));
        if (e.chk_data) chk(op_data == e.data, {e.req, " data"}, op_data, e.data);
      end
    end
  end

  // R12: no request two cycles in a row for isolated writes
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n && op_valid && prev_valid) chk(1'b0, "R12 pulse width", 128'd2, 128'd1);
    prev_valid = op_valid;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [127:0] pd;
    repeat (3) @(negedge clk);
    // R1
    chk(op_valid == 1'b0 && id_sel == 1'b0, "R1 reset outputs", {op_valid, id_sel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(op_valid == 1'b0 && id_sel == 1'b0, "R1 after release", {op_valid, id_sel}, 0);

    // R2: reset command, junk upper bits
    expect_op(4'd0, 32'h0001_0ABC, '0, 1'b0, "R2 reset");
    wr(32'h0001_0ABC, 32'h7777_77F0);
    drained("R2 drained");

    // R3/R4: ID read
    unlock();
    wr(fa(8'h55), 32'hFFFF_FF90);
    expect_op(4'd1, 32'h0000_0400, '0, 1'b0, "R4 id read");
    wr(32'h0000_0400, 32'hABCD_EF00);
    chk(id_sel == 1'b1, "R4 id_sel high", 128'(id_sel), 128'd1);
    @(negedge clk); rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    chk(id_sel == 1'b0, "R4 id_sel after read", 128'(id_sel), 128'd0);
    drained("R3 drained");

    // R5: program, and R10 with 0xF0 as data
    pd = {32'h4444_00F0, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    unlock();
    wr(fa(8'h55), 32'h0000_00A0);
    for (int k = 0; k < 3; k++) wr(32'h0000_8000, pd[k*32 +: 32]);
    expect_op(4'd2, 32'h0000_8000, pd, 1'b1, "R5 program (R10 F0 word)");
    wr(32'h0000_8000, pd[127:96]);
    drained("R5 drained");

    // R6: moved program address aborts
    unlock();
    wr(fa(8'h55), 32'h0000_00A0);
    wr(32'h0000_8000, 32'h1);
    wr(32'h0000_8010, 32'h2);
    wr(32'h0000_8000, 32'h3);
    wr(32'h0000_8000, 32'h4);
    drained("R6 no request");

    // R7: page/block/area erase
    for (int k = 0; k < 3; k++) begin
      logic [7:0] sel;
      sel = (k == 0) ? 8'h40 : (k == 1) ? 8'h30 : 8'h20;
      unlock();
      wr(fa(8'h55), 32'h0000_0080);
      unlock();
      expect_op(4'(3 + k), 32'h0004_0000 + 32'(k * 256), '0, 1'b0, "R7 erase");
      wr(32'h0004_0000 + 32'(k * 256), {24'hA5A5A5, sel});
    end
    drained("R7 drained");

    // R8: code-area and chip erase at 0x55, chip at other field aborts
    unlock(); wr(fa(8'h55), 32'h80); unlock();
    expect_op(4'd6, fa(8'h55), '0, 1'b0, "R8 code area");
    wr(fa(8'h55), 32'h11);
    unlock(); wr(fa(8'h55), 32'h80); unlock();
    expect_op(4'd7, fa(8'h55), '0, 1'b0, "R8 chip");
    wr(fa(8'h55), 32'h10);
    unlock(); wr(fa(8'h55), 32'h80); unlock();
    wr(fa(8'h20), 32'h10);
    drained("R8 off-field abort");

    // R9: protect bit
    unlock();
    wr(fa(8'h55), 32'h9A);
    expect_op(4'd8, 32'h0000_0070, '0, 1'b0, "R9 protect");
    wr(32'h0000_0070, 32'h0101_019A);
    drained("R9 drained");

    // R10: F0 mid-chain resets; wrong field aborts
    unlock();
    expect_op(4'd0, 32'h0000_0123, '0, 1'b0, "R10 F0 mid-chain");
    wr(32'h0000_0123, 32'hF0);
    wr(fa(8'h55), 32'h90);
    wr(32'h0, 32'h00);
    wr(fa(8'h55), 32'hAA);
    wr(fa(8'h33), 32'h55);
    wr(fa(8'h55), 32'h90);
    wr(32'h0, 32'h00);
    drained("R10 abort");
    chk(id_sel == 1'b0, "R10 no id select", 128'(id_sel), 128'd0);

    // R11: busy writes ignored
    busy = 1'b1;
    wr(32'h0, 32'hF0);
    busy = 1'b0;
    drained("R11 busy reset ignored");
    wr(fa(8'h55), 32'hAA);
    busy = 1'b1; wr(32'h0, 32'h12); busy = 1'b0;
    wr(fa(8'hAA), 32'h55);
    busy = 1'b1; wr(fa(8'h55), 32'hA0); busy = 1'b0;
    wr(fa(8'h55), 32'h90);
    expect_op(4'd1, 32'h0000_0500, '0, 1'b0, "R11 chain survives busy");
    wr(32'h0000_0500, 32'h00);
    @(negedge clk); rd_valid = 1'b1;
    @(negedge clk); rd_valid = 1'b0;
    drained("R11 drained");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule